// File: doc/BRIEF.md
# Latched 7-Segment BCD Digit Sequencer

This block walks a packed BCD word out to a row of external latching BCD-to-7-segment decoders, one digit per step. In each step it places a single nibble on a 4-bit data bus. In the same step it drives the latch line of that digit to its load level, so that only that display takes the value. The other displays keep what they were last given. While enable stays high the block runs through the digits again and again, so a changing source word keeps refreshing the displays.

A wide mode drives a second display group from a second source word. Its nibbles appear on a second 4-bit bus at the same moment, and the latch lines are shared between both groups. A 2-bit polarity code sets the logic sense of the outputs to match the display hardware. Bit 1 inverts the data lines and bit 0 inverts the latch lines, each independently of the other. At the end of every complete pass over the digits, a done flag is raised for exactly one step.

Top module: `bcd_latch_seq`

## Requirements
- R1: After reset, with enable low, `done_o` is 0, `data_lo_o` and `data_hi_o` are 0000, and `latch_o` is 1111. This is the hold level with no inversion.
- R2: The first step begins in the cycle after the clock edge that samples `enable_i` high. Each step lasts STEP_CYCLES cycles, and steps visit digits 0, 1, 2, 3 in that order. During the step for digit d, `data_lo_o` carries bits [4d+3:4d] of `word_lo_i`.
- R3: During a step for digit d, latch line d is at the logical load level (0) and every other latch line is at the logical hold level (1).
- R4: When wide mode is captured as 1, `data_hi_o` carries bits [4d+3:4d] of `word_hi_i` in the step for digit d. When wide mode is captured as 0, `data_hi_o` stays at logical 0.
- R5: `done_o` is high for exactly the one step that follows the step for the last digit. That step is the digit-0 step of the next pass. It is low at all other times.
- R6: While enable stays high, passes repeat without a gap: digit 0 follows digit 3 directly.
- R7: Polarity code bit 1 inverts all data lines, so with code 2 the digit 8 appears as 0111. Bit 0 inverts all latch lines. Each bit acts independently of the other.
- R8: The polarity code and the wide flag are captured only in the cycle that starts a run. Changing them while a run is in progress has no effect on any output until the next start.
- R9: From the cycle after the edge that samples enable low, all latch lines sit at the logical hold level and all data lines at logical 0. Both use the polarity captured for the last run, and `done_o` is 0. A new run starts again at digit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| enable_i | input | 1 | Run control; high keeps the sequence cycling |
| wide_i | input | 1 | Wide mode request, captured at run start |
| pol_code_i | input | 2 | Polarity code: bit 1 inverts data, bit 0 inverts latch |
| word_lo_i | input | 16 | First packed BCD source word |
| word_hi_i | input | 16 | Second packed BCD source word (wide mode) |
| data_lo_o | output | 4 | Nibble bus for the first display group |
| data_hi_o | output | 4 | Nibble bus for the second display group |
| latch_o | output | 4 | Per-digit latch lines, shared by both groups |
| done_o | output | 1 | One-step pulse after each complete pass |

## Verification
The bench builds the block with four digits of four bits and STEP_CYCLES set to 3, not the default of 2. With three cycles per step, enable can drop in the first, middle or last cycle of a step. It also means a one-cycle done pulse would be told apart from a pulse that lasts the whole step. With four digits, the bench reaches the wrap from digit 3 back to digit 0 and checks that done lines up with it. Every polarity code is driven in both modes.

// File: rtl/bcdseq_pkg.sv
package bcdseq_pkg;
  // Output sense selection; packed so that code bit 1 is data, bit 0 is latch.
  typedef struct packed {
    logic inv_data;
    logic inv_latch;
  } pol_t;
endpackage

// File: rtl/bcdseq_step_timer.sv
module bcdseq_step_timer #(
  parameter int DIGITS      = 4,
  parameter int STEP_CYCLES = 2,
  localparam int IDX_W = (DIGITS > 1) ? $clog2(DIGITS) : 1,
  localparam int CNT_W = $clog2(STEP_CYCLES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  output logic [IDX_W-1:0] idx_o,
  output logic             step_end_o,
  output logic             wrap_o
);
  localparam logic [IDX_W-1:0] LAST_IDX  = IDX_W'(DIGITS - 1);
  localparam logic [CNT_W-1:0] LAST_TICK = CNT_W'(STEP_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q, cnt_nx;
  logic [IDX_W-1:0] idx_q, idx_nx;
  logic             step_end;

  assign step_end = run && (cnt_q == LAST_TICK);

  always_comb begin
    cnt_nx = cnt_q;
    idx_nx = idx_q;
    if (!run) begin
      cnt_nx = '0;
      idx_nx = '0;
    end else if (step_end) begin
      cnt_nx = '0;
      idx_nx = (idx_q == LAST_IDX) ? '0 : idx_q + IDX_W'(1);
    end else begin
      cnt_nx = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      idx_q <= '0;
    end else begin
      cnt_q <= cnt_nx;
      idx_q <= idx_nx;
    end
  end

  assign idx_o      = idx_q;
  assign step_end_o = step_end;
  assign wrap_o     = step_end && (idx_q == LAST_IDX);

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST_TICK); // R2

  AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (run && step_end) |=> (!run || idx_q == (($past(idx_q) == LAST_IDX) ? '0 : $past(idx_q) + IDX_W'(1)))); // R6
endmodule

// File: rtl/bcdseq_digit_mux.sv
module bcdseq_digit_mux #(
  parameter int DIGITS = 4,
  parameter int NIB_W  = 4,
  localparam int IDX_W  = (DIGITS > 1) ? $clog2(DIGITS) : 1,
  localparam int WORD_W = DIGITS * NIB_W
) (
  input  logic [WORD_W-1:0] word_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic [NIB_W-1:0]  nib_o
);
  logic [NIB_W-1:0] nibs [DIGITS];

  for (genvar g = 0; g < DIGITS; g++) begin : g_split
    assign nibs[g] = word_i[g*NIB_W +: NIB_W];
  end

  always_comb begin
    nib_o = '0;
    for (int k = 0; k < DIGITS; k++) begin
      if (idx_i == IDX_W'(k)) nib_o = nibs[k];
    end
  end
endmodule

// File: rtl/bcdseq_out_stage.sv
module bcdseq_out_stage
  import bcdseq_pkg::*;
#(
  parameter int DIGITS = 4,
  parameter int NIB_W  = 4,
  localparam int IDX_W = (DIGITS > 1) ? $clog2(DIGITS) : 1
) (
  input  logic              run,
  input  logic              wide,
  input  pol_t              pol,
  input  logic [IDX_W-1:0]  idx,
  input  logic [NIB_W-1:0]  nib_lo,
  input  logic [NIB_W-1:0]  nib_hi,
  output logic [NIB_W-1:0]  data_lo_o,
  output logic [NIB_W-1:0]  data_hi_o,
  output logic [DIGITS-1:0] latch_o
);
  logic [DIGITS-1:0] lat_logic;
  logic [NIB_W-1:0]  lo_logic, hi_logic;

  // Logical latch level: 0 = load, 1 = hold.
  for (genvar g = 0; g < DIGITS; g++) begin : g_latch
    assign lat_logic[g] = !(run && (idx == IDX_W'(g)));
  end

  assign lo_logic = run ? nib_lo : '0;
  assign hi_logic = (run && wide) ? nib_hi : '0;

  assign data_lo_o = lo_logic  ^ {NIB_W{pol.inv_data}};
  assign data_hi_o = hi_logic  ^ {NIB_W{pol.inv_data}};
  assign latch_o   = lat_logic ^ {DIGITS{pol.inv_latch}};
endmodule

// File: rtl/bcd_latch_seq.sv
module bcd_latch_seq
  import bcdseq_pkg::*;
#(
  parameter int DIGITS      = 4,
  parameter int NIB_W       = 4,
  parameter int STEP_CYCLES = 2,
  localparam int IDX_W  = (DIGITS > 1) ? $clog2(DIGITS) : 1,
  localparam int WORD_W = DIGITS * NIB_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable_i,
  input  logic              wide_i,
  input  logic [1:0]        pol_code_i,
  input  logic [WORD_W-1:0] word_lo_i,
  input  logic [WORD_W-1:0] word_hi_i,
  output logic [NIB_W-1:0]  data_lo_o,
  output logic [NIB_W-1:0]  data_hi_o,
  output logic [DIGITS-1:0] latch_o,
  output logic              done_o
);
  // Reset: asserted asynchronously, released on a clock edge.
  logic rst_meta, rst_int;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_int  <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_int  <= rst_meta;
    end
  end

  logic             run_q, run_nx;
  logic             wide_q, wide_nx;
  pol_t             pol_q, pol_nx;
  logic             done_q, done_nx;
  logic             start;
  logic [IDX_W-1:0] idx;
  logic             step_end, wrap;
  logic [NIB_W-1:0] nib_lo, nib_hi;

  assign start = enable_i && !run_q;

  always_comb begin
    run_nx  = enable_i;
    wide_nx = wide_q;
    pol_nx  = pol_q;
    done_nx = done_q;
    if (start) begin
      wide_nx = wide_i;
      pol_nx  = pol_t'(pol_code_i);
    end
    if (!enable_i)     done_nx = 1'b0;
    else if (wrap)     done_nx = 1'b1;
    else if (step_end) done_nx = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_int) begin
    if (!rst_int) begin
      run_q  <= 1'b0;
      wide_q <= 1'b0;
      pol_q  <= '0;
      done_q <= 1'b0;
    end else begin
      run_q  <= run_nx;
      wide_q <= wide_nx;
      pol_q  <= pol_nx;
      done_q <= done_nx;
    end
  end

  bcdseq_step_timer #(.DIGITS(DIGITS), .STEP_CYCLES(STEP_CYCLES)) u_timer (
    .clk        (clk),
    .rst_n      (rst_int),
    .run        (run_q),
    .idx_o      (idx),
    .step_end_o (step_end),
    .wrap_o     (wrap)
  );

  bcdseq_digit_mux #(.DIGITS(DIGITS), .NIB_W(NIB_W)) u_mux_lo (
    .word_i (word_lo_i),
    .idx_i  (idx),
    .nib_o  (nib_lo)
  );

  bcdseq_digit_mux #(.DIGITS(DIGITS), .NIB_W(NIB_W)) u_mux_hi (
    .word_i (word_hi_i),
    .idx_i  (idx),
    .nib_o  (nib_hi)
  );

  bcdseq_out_stage #(.DIGITS(DIGITS), .NIB_W(NIB_W)) u_out (
    .run       (run_q),
    .wide      (wide_q),
    .pol       (pol_q),
    .idx       (idx),
    .nib_lo    (nib_lo),
    .nib_hi    (nib_hi),
    .data_lo_o (data_lo_o),
    .data_hi_o (data_hi_o),
    .latch_o   (latch_o)
  );

  assign done_o = done_q;

  AST_ONE_LOAD: assert property (@(posedge clk) disable iff (!rst_int)
    run_q |-> ($countones(latch_o ^ {DIGITS{pol_q.inv_latch}}) == DIGITS - 1)); // R3

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_int)
    !run_q |-> ((latch_o ^ {DIGITS{pol_q.inv_latch}}) == {DIGITS{1'b1}} && !done_o)); // R9

  AST_POL_FROZEN: assert property (@(posedge clk) disable iff (!rst_int)
    (run_q && $past(run_q)) |-> ($stable(pol_q) && $stable(wide_q))); // R8

  AST_DONE_AT_FIRST: assert property (@(posedge clk) disable iff (!rst_int)
    done_o |-> (run_q && idx == '0)); // R5
endmodule

// File: tb/bcd_latch_seq_test.sv
module bcd_latch_seq_test;
  localparam int S = 3;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        enable;
  logic        wide;
  logic [1:0]  pol;
  logic [15:0] wlo, whi;
  logic [3:0]  data_lo, data_hi, latch;
  logic        done;

  int vectors = 0;
  int misses  = 0;
  int cycles  = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  bcd_latch_seq #(.DIGITS(4), .NIB_W(4), .STEP_CYCLES(S)) uut (
    .clk(clk), .rst_n(rst_n), .enable_i(enable), .wide_i(wide),
    .pol_code_i(pol), .word_lo_i(wlo), .word_hi_i(whi),
    .data_lo_o(data_lo), .data_hi_o(data_hi), .latch_o(latch), .done_o(done)
  );

  // Reference state built from the requirements.
  bit       m_run, m_wide, m_done;
  bit [1:0] m_pol;
  int       m_dig, m_cyc;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_run = 0; m_wide = 0; m_done = 0; m_pol = 0; m_dig = 0; m_cyc = 0;
    end else if (!enable) begin
      m_run = 0; m_done = 0;
    end else if (!m_run) begin
      m_run = 1; m_pol = pol; m_wide = wide; m_dig = 0; m_cyc = 0; m_done = 0;
    end else begin
      m_cyc++;
      if (m_cyc == S) begin
        m_cyc = 0;
        if (m_dig == 3) begin m_dig = 0; m_done = 1; end
        else begin m_dig++; m_done = 0; end
      end
    end
  end

  function automatic logic [3:0] nib(input logic [15:0] w, input int d);
    return 4'((w >> (4*d)) & 16'hF);
  endfunction

  function automatic logic [3:0] exp_latch();
    logic [3:0] l = 4'hF;
    if (m_run) l[m_dig] = 1'b0;
    return l ^ {4{m_pol[0]}};
  endfunction

  function automatic logic [3:0] exp_lo();
    return (m_run ? nib(wlo, m_dig) : 4'h0) ^ {4{m_pol[1]}};
  endfunction

  function automatic logic [3:0] exp_hi();
    return ((m_run && m_wide) ? nib(whi, m_dig) : 4'h0) ^ {4{m_pol[1]}};
  endfunction

  task automatic cmp(input string tag, input logic [3:0] act, input logic [3:0] exp);
    if (act !== exp) begin
      misses++;
      $display("FAIL %s: actual %b expected %b (cycle %0d)", tag, act, exp, cycles);
    end
  endtask

  // One vector: all outputs against the model (R2/R7 data, R3 latch, R4 hi, R5 done).
  task automatic check_all();
    vectors++;
    cmp("R2/R7 data_lo", data_lo, exp_lo());
    cmp("R3/R7 latch", latch, exp_latch());
    cmp("R4 data_hi", data_hi, exp_hi());
    cmp("R5 done", {3'b0, done}, {3'b0, m_done});
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check_all();
    end
  endtask

  // Watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      misses++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    rst_n = 0; enable = 0; wide = 0; pol = 0; wlo = 16'h1234; whi = 16'h5678;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    // R1: reset state
    vectors++;
    cmp("R1 latch", latch, 4'hF);
    cmp("R1 data_lo", data_lo, 4'h0);
    cmp("R1 data_hi", data_hi, 4'h0);
    cmp("R1 done", {3'b0, done}, 4'h0);

    // R7 directed: code 2, digit 8 appears as 0111 on digit-0 step.
    wlo = 16'h0008; pol = 2'd2; wide = 0; enable = 1;
    @(negedge clk);
    vectors++;
    cmp("R7 digit8 inverted", data_lo, 4'b0111);
    cmp("R7 latch same sense", latch, 4'b1110);
    // R6 and R5: two full passes with wrap and done.
    tick(8*S);
    // R8: change polarity and wide mid-run; outputs must follow captured values.
    pol = 2'd1; wide = 1;
    tick(5*S);
    // R9: drop enable; idle levels under captured code 2.
    enable = 0;
    @(negedge clk);
    vectors++;
    cmp("R9 idle latch", latch, 4'hF);
    cmp("R9 idle data", data_lo, 4'hF);
    cmp("R9 idle done", {3'b0, done}, 4'h0);
    tick(2);

    // Every polarity code in both modes.
    for (int p = 0; p < 4; p++) begin
      for (int w = 0; w < 2; w++) begin
        pol = 2'(p); wide = 1'(w);
        wlo = 16'h9876; whi = 16'h0459;
        enable = 1;
        tick(4*S + 2);
        enable = 0;
        tick(2);
      end
    end

    // Constrained random episodes; enable drops at arbitrary step phases (R9, R2).
    for (int e = 0; e < 300; e++) begin
      pol  = 2'($urandom_range(0, 3));
      wide = 1'($urandom_range(0, 1));
      for (int d = 0; d < 4; d++) begin
        wlo[4*d +: 4] = 4'($urandom_range(0, 9));
        whi[4*d +: 4] = 4'($urandom_range(0, 9));
      end
      enable = 1;
      for (int c = $urandom_range(1, 40); c > 0; c--) begin
        @(negedge clk);
        check_all();
        if ($urandom_range(0, 7) == 0) wlo = 16'($urandom);
        if ($urandom_range(0, 9) == 0) pol = 2'($urandom_range(0, 3)); // R8
        if ($urandom_range(0, 9) == 0) wide = ~wide;                   // R8
      end
      enable = 0;
      tick($urandom_range(1, 4));
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule